// File: doc/BRIEF.md
# Table-Driven Call and Return Unit

This unit carries out a short-form indirect call through a table of 16-bit offsets, and the matching return. A call names one of 64 table slots through a 6-bit index. The unit first stores the return address, which is the current PC plus 2, and the current status word in two private save registers. It then reads the halfword in the chosen slot and jumps to the table base plus that halfword. A return puts the saved PC and saved status word back. No stack is used.

The controller is a three-state machine. In `ST_IDLE` it accepts a command. A call moves it to `ST_FETCH` (transition *call-accept*). A return moves it straight to `ST_COMMIT` (transition *ret-accept*). It stays in `ST_FETCH` with the read request held until the read data is valid (transition *fetch-wait*). On valid data it moves to `ST_COMMIT` (transition *fetch-done*). `ST_COMMIT` lasts one cycle, raises `done` and goes back to `ST_IDLE` (transition *commit-exit*). Instruction fetch, decode and exception handling are outside this unit.

Top module: `tcr_unit`

## Requirements
- R1: After reset, `done`, `busy`, `mem_req` and `psw_wr` are 0, and `pc_out` and `psw_out` are 0.
- R2: During a call's fetch, `mem_addr` equals `tbl_base + (zero-extended cmd_index << 1)`, modulo 2^AW.
- R3: A call's committed `pc_out` equals `tbl_base` plus the zero-extended `mem_rdata`, modulo 2^AW, with bit 0 forced to 0.
- R4: A call stores `pc_in + 2` (modulo 2^AW) and `psw_in`. A later return drives exactly those values on `pc_out` and `psw_out`.
- R5: From the cycle after a call is accepted, `mem_req` stays high and `mem_addr` stays constant until the cycle in which `mem_rvalid` is seen. Any number of wait cycles is allowed.
- R6: `done` is high for exactly one cycle. For a call it is high in the cycle after `mem_rvalid` was sampled with `mem_req` high. For a return it is high in the cycle after the command was accepted.
- R7: `cmd_valid` is ignored while `busy` is high, including the `done` cycle. Such a command changes neither the fetch address nor the save registers, and it produces no extra `done`.
- R8: `psw_wr` is high only in the `done` cycle of a return. A call leaves `psw_out` unchanged.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle, and low again afterwards.
- R10: `mem_rvalid` while no read is pending has no effect: no `done`, no `busy` and no `mem_req` follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_ret | input | 1 | 1 = return, 0 = call |
| cmd_index | input | IW (6) | Table slot for a call |
| pc_in | input | AW (32) | Current program counter |
| psw_in | input | PW (32) | Current status word |
| tbl_base | input | AW (32) | Table base register value |
| mem_req | output | 1 | Halfword read request, held until valid |
| mem_addr | output | AW (32) | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | HW (16) | Read halfword |
| pc_out | output | AW (32) | Committed program counter, meaningful with `done` |
| psw_out | output | PW (32) | Restored status word |
| psw_wr | output | 1 | Status word write strobe, returns only |
| done | output | 1 | One-cycle commit pulse |
| busy | output | 1 | A command is in progress |

## Verification
The assertions check on every cycle that `done` is a single-cycle pulse and that the read request and address hold steady while a read is pending. They also check that a call's commit always follows a sampled read, that `psw_wr` only appears with `done`, and that the save registers change only when a call is accepted. Only the bench's scenarios can show that the arithmetic is right: the slot address, the base-plus-offset target with bit 0 cleared, wrap-around past 2^32, and PC+2. The same goes for the exact commit latency for every read delay, and for the fact that commands arriving mid-operation or in the `done` cycle leave no trace in a later return.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_COMMIT = 2'd2
    } tcr_state_e;
endpackage

// File: rtl/tcr_ctrl.sv
module tcr_ctrl
    import tcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_ret,
    input  logic mem_rvalid,
    output logic accept_call,
    output logic accept_ret,
    output logic fetch_done,
    output logic mem_req,
    output logic in_commit,
    output logic busy
);
    tcr_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid && !cmd_ret)     state_d = ST_FETCH;   // call-accept
                else if (cmd_valid && cmd_ret) state_d = ST_COMMIT;  // ret-accept
            end
            ST_FETCH: begin
                if (mem_rvalid) state_d = ST_COMMIT;                 // fetch-done
            end
            ST_COMMIT: state_d = ST_IDLE;                            // commit-exit
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept_call = 1'b0;
        accept_ret  = 1'b0;
        fetch_done  = 1'b0;
        mem_req     = 1'b0;
        in_commit   = 1'b0;
        busy        = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy        = 1'b0;
                accept_call = cmd_valid && !cmd_ret;
                accept_ret  = cmd_valid && cmd_ret;
            end
            ST_FETCH: begin
                mem_req    = 1'b1;
                fetch_done = mem_rvalid;
            end
            ST_COMMIT: in_commit = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // R7: no command is taken while an operation is in flight
    a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || in_commit) |-> !(accept_call || accept_ret));
endmodule

// File: rtl/tcr_save_regs.sv
module tcr_save_regs #(
    parameter int AW = 32,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [AW-1:0] pc_in,
    input  logic [PW-1:0] psw_in,
    output logic [AW-1:0] save_pc,
    output logic [PW-1:0] save_psw
);
    localparam logic [AW-1:0] RET_STEP = AW'(2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_pc  <= '0;
            save_psw <= '0;
        end else if (cap_en) begin
            save_pc  <= pc_in + RET_STEP;
            save_psw <= psw_in;
        end
    end

    // R4/R7: save registers only move on an accepted call
    a_r4_save_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(save_pc) && $stable(save_psw)));
endmodule

// File: rtl/tcr_path.sv
module tcr_path #(
    parameter int AW = 32,
    parameter int PW = 32,
    parameter int HW = 16,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_call,
    input  logic          accept_ret,
    input  logic          fetch_done,
    input  logic [IW-1:0] cmd_index,
    input  logic [AW-1:0] tbl_base,
    input  logic [HW-1:0] mem_rdata,
    input  logic [AW-1:0] save_pc,
    input  logic [PW-1:0] save_psw,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] new_pc,
    output logic [PW-1:0] new_psw,
    output logic          is_ret
);
    localparam int SLOT_PAD = AW - IW - 1;
    localparam int DATA_PAD = AW - HW;
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(1);

    logic [AW-1:0] base_q;
    logic [AW-1:0] slot_off;
    logic [AW-1:0] entry_ext;

    assign slot_off  = {{SLOT_PAD{1'b0}}, cmd_index, 1'b0};
    assign entry_ext = {{DATA_PAD{1'b0}}, mem_rdata};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            mem_addr <= '0;
            new_pc   <= '0;
            new_psw  <= '0;
            is_ret   <= 1'b0;
        end else begin
            if (accept_call) begin
                base_q   <= tbl_base;
                mem_addr <= tbl_base + slot_off;
                is_ret   <= 1'b0;
            end
            if (fetch_done) begin
                new_pc <= (base_q + entry_ext) & ALIGN_MASK;
            end
            if (accept_ret) begin
                new_pc  <= save_pc;
                new_psw <= save_psw;
                is_ret  <= 1'b1;
            end
        end
    end

    // R8: status word only moves on an accepted return
    a_r8_psw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_ret |=> $stable(new_psw));
endmodule

// File: rtl/tcr_unit.sv
module tcr_unit #(
    parameter int AW = 32,
    parameter int PW = 32,
    parameter int HW = 16,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_ret,
    input  logic [IW-1:0] cmd_index,
    input  logic [AW-1:0] pc_in,
    input  logic [PW-1:0] psw_in,
    input  logic [AW-1:0] tbl_base,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [HW-1:0] mem_rdata,
    output logic [AW-1:0] pc_out,
    output logic [PW-1:0] psw_out,
    output logic          psw_wr,
    output logic          done,
    output logic          busy
);
    logic          accept_call;
    logic          accept_ret;
    logic          fetch_done;
    logic          in_commit;
    logic          is_ret;
    logic [AW-1:0] save_pc;
    logic [PW-1:0] save_psw;

    tcr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ret    (cmd_ret),
        .mem_rvalid (mem_rvalid),
        .accept_call(accept_call),
        .accept_ret (accept_ret),
        .fetch_done (fetch_done),
        .mem_req    (mem_req),
        .in_commit  (in_commit),
        .busy       (busy)
    );

    tcr_save_regs #(.AW(AW), .PW(PW)) u_save (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (accept_call),
        .pc_in   (pc_in),
        .psw_in  (psw_in),
        .save_pc (save_pc),
        .save_psw(save_psw)
    );

    tcr_path #(.AW(AW), .PW(PW), .HW(HW), .IW(IW)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_call(accept_call),
        .accept_ret (accept_ret),
        .fetch_done (fetch_done),
        .cmd_index  (cmd_index),
        .tbl_base   (tbl_base),
        .mem_rdata  (mem_rdata),
        .save_pc    (save_pc),
        .save_psw   (save_psw),
        .mem_addr   (mem_addr),
        .new_pc     (pc_out),
        .new_psw    (psw_out),
        .is_ret     (is_ret)
    );

    assign done   = in_commit;
    assign psw_wr = in_commit && is_ret;

    // R6: commit is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a call commit always follows a sampled read
    a_r6_call_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !psw_wr) |-> $past(mem_req && mem_rvalid));

    // R5: request and address hold until data arrives
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R5: a pending read only ends in a commit
    a_r5_fetch_exit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (mem_req || done));

    // R8: status write only with a commit
    a_r8_psw_wr_done: assert property (@(posedge clk) disable iff (!rst_n)
        psw_wr |-> done);
endmodule

// File: tb/tcr_unit_tb.sv
module tcr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_ret;
    logic [5:0]  cmd_index;
    logic [31:0] pc_in, psw_in, tbl_base;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [15:0] mem_rdata;
    logic [31:0] pc_out, psw_out;
    logic        psw_wr, done, busy;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [31:0] exp_save_pc, exp_save_psw, exp_psw_out;

    always #10 clk = ~clk;

    tcr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ret(cmd_ret),
        .cmd_index(cmd_index), .pc_in(pc_in), .psw_in(psw_in), .tbl_base(tbl_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .pc_out(pc_out), .psw_out(psw_out),
        .psw_wr(psw_wr), .done(done), .busy(busy)
    );

    function automatic logic [15:0] tbl_entry(input logic [31:0] a);
        return 16'(a[15:0] * 16'd2663 + a[31:16] + 16'h03C5);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_call(input logic [31:0] base, input logic [5:0] idx,
                           input logic [31:0] pcv, input logic [31:0] pswv,
                           input int dly, input bit hit_commit);
        logic [31:0] exp_addr;
        logic [15:0] ent;
        exp_addr = base + {25'd0, idx, 1'b0};
        ent      = tbl_entry(exp_addr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_ret = 1'b0; cmd_index = idx;
        tbl_base = base; pc_in = pcv; psw_in = pswv;
        for (int n = 0; n <= dly; n++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R5 mem_req held", 32'(mem_req), 32'd1);
            chk("R9 busy in fetch", 32'(busy), 32'd1);
            chk("R6 no early done", 32'(done), 32'd0);
            chk("R2 slot address", mem_addr, exp_addr);
            if (n == dly) begin
                mem_rvalid = 1'b1;
                mem_rdata  = ent;
            end else if (n == 0) begin
                // R7: foreign commands while busy
                cmd_valid = 1'b1; cmd_ret = idx[0]; cmd_index = ~idx;
                tbl_base = ~base; pc_in = ~pcv; psw_in = ~pswv;
            end
        end
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 16'hDEAD; cmd_valid = 1'b0;
        chk("R6 call done", 32'(done), 32'd1);
        chk("R3 target", pc_out, (base + {16'd0, ent}) & ~32'd1);
        chk("R8 no psw_wr on call", 32'(psw_wr), 32'd0);
        chk("R8 psw_out kept", psw_out, exp_psw_out);
        chk("R9 busy at done", 32'(busy), 32'd1);
        exp_save_pc  = pcv + 32'd2;
        exp_save_psw = pswv;
        if (hit_commit) begin
            // R7: command in the done cycle is dropped
            cmd_valid = 1'b1; cmd_ret = 1'b1; pc_in = 32'h0; psw_in = 32'h0;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R6 done one cycle", 32'(done), 32'd0);
        chk("R9 idle after", 32'(busy), 32'd0);
        chk("R7 no stray req", 32'(mem_req), 32'd0);
    endtask

    task automatic do_ret();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_ret = 1'b1; pc_in = 32'h5555_5555; psw_in = 32'h6666_6666;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R6 ret done", 32'(done), 32'd1);
        chk("R4 restored pc", pc_out, exp_save_pc);
        chk("R4 restored psw", psw_out, exp_save_psw);
        chk("R8 psw_wr on ret", 32'(psw_wr), 32'd1);
        exp_psw_out = exp_save_psw;
        @(negedge clk);
        chk("R6 ret done one cycle", 32'(done), 32'd0);
        chk("R8 psw_wr drops", 32'(psw_wr), 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] bases [3];
        bases[0] = 32'h0000_1000;
        bases[1] = 32'hFFFF_FF80;
        bases[2] = 32'h1234_5679;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_ret = 1'b0; cmd_index = '0;
        pc_in = '0; psw_in = '0; tbl_base = '0; mem_rvalid = 1'b0; mem_rdata = '0;
        exp_psw_out = '0;
        repeat (3) @(negedge clk);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        chk("R1 psw_wr", 32'(psw_wr), 32'd0);
        chk("R1 pc_out", pc_out, 32'd0);
        chk("R1 psw_out", psw_out, 32'd0);
        rst_n = 1'b1;
        // R10: stray valid while idle
        @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = 16'h1234;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk("R10 no done", 32'(done), 32'd0);
        chk("R10 no busy", 32'(busy), 32'd0);
        chk("R10 no req", 32'(mem_req), 32'd0);
        chk("R10 pc_out kept", pc_out, 32'd0);
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 64; i++) begin
                logic [31:0] pcv, pswv;
                pcv  = bases[b] ^ (32'(i) * 32'h0101_0101);
                pswv = 32'hA500_0000 + 32'(i) * 32'd7 + 32'(b);
                if (b == 1 && i == 63) pcv = 32'hFFFF_FFFE;
                do_call(bases[b], 6'(i), pcv, pswv, i % 4, (i % 5) == 0);
                if ((i % 8) == 7) do_ret();
            end
        end
        // R4: two calls back to back, return sees the latest
        do_call(32'h0000_2000, 6'd5, 32'h0000_0100, 32'h0000_0011, 0, 1'b0);
        do_call(32'h0000_3000, 6'd9, 32'h0000_0200, 32'h0000_0022, 6, 1'b1);
        do_ret();
        do_ret();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule